// File: doc/BRIEF.md
# Platform Sleep-State Power Sequencer

This block is a synchronous state machine that walks a processor platform through four resting power levels: hard-off, soft-off, suspend and on. Between each neighbouring pair there is a dedicated transition state, so the machine has ten states in all. On the input side it samples three power-good flags (always-on rail, memory rail, switched non-core rails) and two active-low sleep-request lines from the chipset. On the output side it drives the memory, switched and core rail enables. It also drives the deep-sleep power-ok, the active-low resume reset, the processor power-ok and a thermal throttle line.

Every delay and every timeout is a parameter, counted in pulses of a free-running `tick_i` input. A wake request moves the machine out of hard-off. If a required rail drops, or a wait for a rail times out, the machine forces a shutdown: deep-sleep power-ok goes low and resume reset is asserted in the same cycle. It then falls back one level.

The suspend-acknowledge output is a combinational copy of the suspend-warning input. A query port takes a mask of coarse states and reports whether the current state is covered by that mask.

Top module: `pwr_seq_fsm`

## Requirements
- R1: After reset the machine is in hard-off and all of the following are 0: `en_mem_o`, `en_sw_o`, `en_core_o`, `dsw_pwrok_o`, `rsm_rst_n_o`, `cpu_pwrok_o` and `throttle_o`.
- R2: Hard-off is left only when `wake_req_i` is sampled high, either in hard-off or during the soft-off to hard-off step. Then T_PRE_DSW ticks pass, `dsw_pwrok_o` and `rsm_rst_n_o` rise together, T_SUSCLK more ticks pass, and the machine is in soft-off.
- R3: In soft-off with `slp_s5_n_i` low for T_IDLE ticks, the machine drops `dsw_pwrok_o` and `rsm_rst_n_o`, then enters hard-off.
- R4: In soft-off, `slp_s5_n_i` high starts the climb to suspend. `en_mem_o` rises only after `pg_aon_i` is seen high. Suspend is entered once both `pg_aon_i` and `pg_mem_i` are high. If either wait lasts T_RAIL ticks, the machine forces shutdown, clears `en_mem_o` and returns to soft-off.
- R5: In suspend the checks run in this order of priority: first, loss of `pg_aon_i` or `pg_mem_i` forces shutdown and heads to soft-off; then `slp_s3_n_i` high heads to on; then `slp_s5_n_i` low heads to soft-off.
- R6: Suspend to on sets `en_sw_o` on the first edge. It waits for all three power-good flags (T_RAIL tick timeout: forced shutdown, `en_sw_o` cleared, back to suspend), then sets `en_core_o`. T_CORE ticks later, in the same edge, it loads `throttle_o` from `throttle_req_i` and sets `cpu_pwrok_o`. `en_core_o` implies `en_sw_o`, and `en_sw_o` implies `en_mem_o`.
- R7: In on, loss of any of the three power-good flags forces shutdown on the next edge (`dsw_pwrok_o` 0, `rsm_rst_n_o` 0) and leads to suspend.
- R8: On to suspend, on successive edges: `cpu_pwrok_o` falls; then `en_core_o` and `throttle_o` fall; then `en_sw_o` falls and suspend is entered. A low `slp_s3_n_i` in on starts this path.
- R9: Suspend to soft-off clears `en_mem_o` and enters soft-off two edges after the request. `dsw_pwrok_o` is left unchanged.
- R10: `sus_ack_n_o` equals `sus_warn_n_i` at all times, with no clock delay.
- R11: Query mask bits are: bit0 hard-off, bit1 soft-off, bit2 suspend, bit3 on. A resting state maps to its own bit; a transition state maps to both of its end states. `query_hit_o` is 1 exactly when the mask holds every bit the current state maps to.
- R12: In on, `throttle_o` follows `throttle_req_i` one edge later. Outside on, a change of `throttle_req_i` does not reach `throttle_o` until the next entry to on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase pulse; all delays count these |
| wake_req_i | input | 1 | Request to leave hard-off |
| pg_aon_i | input | 1 | Always-on rail good |
| pg_mem_i | input | 1 | Memory rail good |
| pg_sw_i | input | 1 | Switched non-core rails good |
| slp_s3_n_i | input | 1 | Active-low suspend-level sleep request |
| slp_s5_n_i | input | 1 | Active-low soft-off-level sleep request |
| sus_warn_n_i | input | 1 | Active-low suspend warning from chipset |
| throttle_req_i | input | 1 | Thermal throttle request |
| query_mask_i | input | 4 | Coarse-state mask for the query |
| en_mem_o | output | 1 | Memory rail enable |
| en_sw_o | output | 1 | Switched rail enable |
| en_core_o | output | 1 | Core regulator enable |
| dsw_pwrok_o | output | 1 | Deep-sleep power-ok |
| rsm_rst_n_o | output | 1 | Active-low resume reset |
| cpu_pwrok_o | output | 1 | Processor power-ok |
| throttle_o | output | 1 | Thermal throttle output |
| sus_ack_n_o | output | 1 | Suspend acknowledge, copy of warning |
| query_hit_o | output | 1 | Current state covered by query mask |

## Verification
Every registered output changes on the first edge that samples its cause. Input-driven steps are therefore due one edge after the stimulus. A timed phase of N ticks with a permanent tick ends on the Nth edge after the phase begins. The on-to-suspend path moves one output group per edge. The bench drives inputs and samples at falling edges, and counts rising edges to the exact cycle. It checks both the cycle before an expected change (value unchanged) and the cycle of the change. `sus_ack_n_o` and `query_hit_o` are combinational and are sampled one time unit after the input changes.

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm #(
  parameter int T_PRE_DSW = 10,
  parameter int T_SUSCLK  = 5,
  parameter int T_IDLE    = 10000,
  parameter int T_RAIL    = 1000,
  parameter int T_CORE    = 99
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wake_req_i,
  input  logic       pg_aon_i,
  input  logic       pg_mem_i,
  input  logic       pg_sw_i,
  input  logic       slp_s3_n_i,
  input  logic       slp_s5_n_i,
  input  logic       sus_warn_n_i,
  input  logic       throttle_req_i,
  input  logic [3:0] query_mask_i,
  output logic       en_mem_o,
  output logic       en_sw_o,
  output logic       en_core_o,
  output logic       dsw_pwrok_o,
  output logic       rsm_rst_n_o,
  output logic       cpu_pwrok_o,
  output logic       throttle_o,
  output logic       sus_ack_n_o,
  output logic       query_hit_o
);
  localparam int TMAX = (T_IDLE > T_RAIL) ? ((T_IDLE > T_CORE) ? T_IDLE : T_CORE)
                                          : ((T_RAIL > T_CORE) ? T_RAIL : T_CORE);
  localparam int TALL = (TMAX > T_PRE_DSW) ? ((TMAX > T_SUSCLK) ? TMAX : T_SUSCLK)
                                           : ((T_PRE_DSW > T_SUSCLK) ? T_PRE_DSW : T_SUSCLK);
  localparam int CW   = $clog2(TALL + 1);

  typedef enum logic [3:0] {
    S_HOFF, S_SOFF, S_SUSP, S_ON,
    S_HOFF_SOFF, S_SOFF_SUSP, S_SUSP_ON, S_ON_SUSP, S_SUSP_SOFF, S_SOFF_HOFF
  } st_t;

  st_t           st;
  logic [1:0]    ph;
  logic [CW-1:0] cnt, lim;
  logic          wake_pend, expired, rails_s3, rails_s0, in_on;
  logic [3:0]    need;

  assign rails_s3    = pg_aon_i & pg_mem_i;
  assign rails_s0    = rails_s3 & pg_sw_i;
  assign in_on       = (st == S_ON);
  assign sus_ack_n_o = sus_warn_n_i;
  assign expired     = tick_i && (cnt == lim - 1'b1);

  always_comb begin
    case (st)
      S_HOFF_SOFF: lim = (ph == 2'd0) ? CW'(T_PRE_DSW) : CW'(T_SUSCLK);
      S_SOFF:      lim = CW'(T_IDLE);
      S_SOFF_SUSP: lim = CW'(T_RAIL);
      S_SUSP_ON:   lim = (ph == 2'd0) ? CW'(T_RAIL) : CW'(T_CORE);
      default:     lim = CW'(1);
    endcase
  end

  always_comb begin
    case (st)
      S_HOFF:                   need = 4'b0001;
      S_SOFF:                   need = 4'b0010;
      S_SUSP:                   need = 4'b0100;
      S_ON:                     need = 4'b1000;
      S_HOFF_SOFF, S_SOFF_HOFF: need = 4'b0011;
      S_SOFF_SUSP, S_SUSP_SOFF: need = 4'b0110;
      default:                  need = 4'b1100;
    endcase
  end
  assign query_hit_o = ((query_mask_i & need) == need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_HOFF;
      ph          <= 2'd0;
      cnt         <= '0;
      wake_pend   <= 1'b0;
      en_mem_o    <= 1'b0;
      en_sw_o     <= 1'b0;
      en_core_o   <= 1'b0;
      dsw_pwrok_o <= 1'b0;
      rsm_rst_n_o <= 1'b0;
      cpu_pwrok_o <= 1'b0;
      throttle_o  <= 1'b0;
    end else begin
      if (wake_req_i && st == S_SOFF_HOFF) wake_pend <= 1'b1;
      case (st)
        S_HOFF:
          if (wake_req_i || wake_pend) begin
            wake_pend <= 1'b0;
            st <= S_HOFF_SOFF; ph <= 2'd0; cnt <= '0;
          end
        S_HOFF_SOFF:
          if (expired) begin
            cnt <= '0;
            if (ph == 2'd0) begin
              dsw_pwrok_o <= 1'b1;
              rsm_rst_n_o <= 1'b1;
              ph <= 2'd1;
            end else begin
              st <= S_SOFF; ph <= 2'd0;
            end
          end else if (tick_i) cnt <= cnt + 1'b1;
        S_SOFF:
          if (slp_s5_n_i) begin
            st <= S_SOFF_SUSP; ph <= 2'd0; cnt <= '0;
          end else if (expired) begin
            st <= S_SOFF_HOFF; cnt <= '0; wake_pend <= 1'b0;
          end else if (tick_i) cnt <= cnt + 1'b1;
        S_SOFF_HOFF: begin
          dsw_pwrok_o <= 1'b0;
          rsm_rst_n_o <= 1'b0;
          st <= S_HOFF;
        end
        S_SOFF_SUSP:
          if (ph == 2'd0 && pg_aon_i) begin
            en_mem_o <= 1'b1; ph <= 2'd1; cnt <= '0;
          end else if (ph != 2'd0 && rails_s3) begin
            st <= S_SUSP; ph <= 2'd0; cnt <= '0;
          end else if (expired) begin
            dsw_pwrok_o <= 1'b0;
            rsm_rst_n_o <= 1'b0;
            en_mem_o    <= 1'b0;
            st <= S_SOFF; ph <= 2'd0; cnt <= '0;
          end else if (tick_i) cnt <= cnt + 1'b1;
        S_SUSP:
          if (!rails_s3) begin
            dsw_pwrok_o <= 1'b0;
            rsm_rst_n_o <= 1'b0;
            st <= S_SUSP_SOFF;
          end else if (slp_s3_n_i) begin
            en_sw_o <= 1'b1;
            st <= S_SUSP_ON; ph <= 2'd0; cnt <= '0;
          end else if (!slp_s5_n_i) begin
            st <= S_SUSP_SOFF;
          end
        S_SUSP_ON:
          if (ph == 2'd0) begin
            if (rails_s0) begin
              en_core_o <= 1'b1; ph <= 2'd1; cnt <= '0;
            end else if (expired) begin
              dsw_pwrok_o <= 1'b0;
              rsm_rst_n_o <= 1'b0;
              en_sw_o     <= 1'b0;
              st <= S_SUSP; cnt <= '0;
            end else if (tick_i) cnt <= cnt + 1'b1;
          end else if (expired) begin
            throttle_o  <= throttle_req_i;
            cpu_pwrok_o <= 1'b1;
            st <= S_ON; ph <= 2'd0; cnt <= '0;
          end else if (tick_i) cnt <= cnt + 1'b1;
        S_ON: begin
          throttle_o <= throttle_req_i;
          if (!rails_s0) begin
            dsw_pwrok_o <= 1'b0;
            rsm_rst_n_o <= 1'b0;
            st <= S_ON_SUSP; ph <= 2'd0;
          end else if (!slp_s3_n_i) begin
            st <= S_ON_SUSP; ph <= 2'd0;
          end
        end
        S_ON_SUSP:
          case (ph)
            2'd0: begin cpu_pwrok_o <= 1'b0; ph <= 2'd1; end
            2'd1: begin en_core_o <= 1'b0; throttle_o <= 1'b0; ph <= 2'd2; end
            default: begin en_sw_o <= 1'b0; st <= S_SUSP; ph <= 2'd0; end
          endcase
        S_SUSP_SOFF: begin
          en_mem_o <= 1'b0;
          st <= S_SOFF; cnt <= '0;
        end
        default: st <= S_HOFF;
      endcase
    end
  end
endmodule

// File: rtl/pwr_seq_fsm_chk.sv
module pwr_seq_fsm_chk (
  input logic clk,
  input logic rst_n,
  input logic in_on,
  input logic pg_aon_i,
  input logic pg_mem_i,
  input logic pg_sw_i,
  input logic sus_warn_n_i,
  input logic sus_ack_n_o,
  input logic en_mem_o,
  input logic en_sw_o,
  input logic en_core_o,
  input logic dsw_pwrok_o,
  input logic rsm_rst_n_o,
  input logic cpu_pwrok_o,
  input logic throttle_o
);
  p_ack_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sus_ack_n_o == sus_warn_n_i);

  p_pwrok_core_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_pwrok_o |-> en_core_o);

  p_core_sw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_core_o |-> en_sw_o);

  p_sw_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_sw_o |-> en_mem_o);

  p_pwrok_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_core_o) |-> !$past(cpu_pwrok_o));

  p_on_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_on && !(pg_aon_i && pg_mem_i && pg_sw_i)) |=> (!dsw_pwrok_o && !rsm_rst_n_o));

  p_throttle_core_r12: assert property (@(posedge clk) disable iff (!rst_n)
    throttle_o |-> en_core_o);
endmodule

bind pwr_seq_fsm pwr_seq_fsm_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_on(in_on),
  .pg_aon_i(pg_aon_i), .pg_mem_i(pg_mem_i), .pg_sw_i(pg_sw_i),
  .sus_warn_n_i(sus_warn_n_i), .sus_ack_n_o(sus_ack_n_o),
  .en_mem_o(en_mem_o), .en_sw_o(en_sw_o), .en_core_o(en_core_o),
  .dsw_pwrok_o(dsw_pwrok_o), .rsm_rst_n_o(rsm_rst_n_o),
  .cpu_pwrok_o(cpu_pwrok_o), .throttle_o(throttle_o)
);

// File: tb/pwr_seq_fsm_tb_top.sv
module pwr_seq_fsm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 4, SUS = 3, IDLE = 20, RAIL = 10, CORE = 6;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, wake = 1'b0;
  logic pg_aon = 1'b0, pg_mem = 1'b0, pg_sw = 1'b0;
  logic s3n = 1'b0, s5n = 1'b0, warn_n = 1'b1, thr_req = 1'b0;
  logic [3:0] qmask = 4'b0000;
  logic en_mem, en_sw, en_core, dsw, rsm_n, pwrok, thr, ack_n, hit;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_fsm #(.T_PRE_DSW(PRE), .T_SUSCLK(SUS), .T_IDLE(IDLE), .T_RAIL(RAIL), .T_CORE(CORE)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wake_req_i(wake),
    .pg_aon_i(pg_aon), .pg_mem_i(pg_mem), .pg_sw_i(pg_sw),
    .slp_s3_n_i(s3n), .slp_s5_n_i(s5n), .sus_warn_n_i(warn_n),
    .throttle_req_i(thr_req), .query_mask_i(qmask),
    .en_mem_o(en_mem), .en_sw_o(en_sw), .en_core_o(en_core),
    .dsw_pwrok_o(dsw), .rsm_rst_n_o(rsm_n), .cpu_pwrok_o(pwrok),
    .throttle_o(thr), .sus_ack_n_o(ack_n), .query_hit_o(hit)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic q(input logic [3:0] m, output logic h);
    qmask = m; #1; h = hit;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_for(input logic [3:0] m, input int max, input string req);
    logic h;
    q(m, h);
    for (int i = 0; i < max && !h; i++) begin
      step(1); q(m, h);
    end
    check(req, h, 1);
  endtask

  task automatic t_reset;
    logic h;
    q(4'b0001, h);
    check("R1 hard-off", h, 1);
    check("R1 outputs", {en_mem, en_sw, en_core, dsw, rsm_n, pwrok, thr}, 0);
  endtask

  task automatic t_wake;
    logic h;
    step(30); q(4'b0001, h);
    check("R2 no wake stays hard-off", h, 1);
    check("R2 no wake dsw", dsw, 0);
    wake = 1'b1; step(1); wake = 1'b0;
    step(PRE - 1);
    check("R2 dsw before delay", dsw, 0);
    step(1);
    check("R2 dsw after delay", dsw, 1);
    check("R2 rsm after delay", rsm_n, 1);
    step(SUS - 1); q(4'b0010, h);
    check("R2 not yet soft-off", h, 0);
    step(1); q(4'b0010, h);
    check("R2 soft-off", h, 1);
  endtask

  task automatic t_idle;
    logic h;
    step(IDLE - 1); q(4'b0001, h);
    check("R3 early hard-off", h, 0);
    wait_for(4'b0001, 5, "R3 hard-off after idle");
    check("R3 dsw", dsw, 0);
    check("R3 rsm", rsm_n, 0);
  endtask

  task automatic t_climb_s3;
    logic h;
    wake = 1'b1; step(1); wake = 1'b0;
    wait_for(4'b0010, PRE + SUS + 4, "R2 rewake soft-off");
    s5n = 1'b1; step(3); q(4'b0110, h);
    check("R4 waiting aon", h, 1);
    check("R4 mem off before aon", en_mem, 0);
    pg_aon = 1'b1; step(1);
    check("R4 mem on after aon", en_mem, 1);
    pg_mem = 1'b1; step(1); q(4'b0100, h);
    check("R4 suspend reached", h, 1);
  endtask

  task automatic t_s3_to_s0;
    logic h;
    thr_req = 1'b1; step(1);
    check("R12 throttle held outside on", thr, 0);
    s3n = 1'b1; step(1);
    check("R6 sw on", en_sw, 1);
    q(4'b0100, h); check("R11 suspend-only mask misses", h, 0);
    q(4'b1000, h); check("R11 on-only mask misses", h, 0);
    q(4'b1100, h); check("R11 both-ends mask hits", h, 1);
    check("R6 core waits rails", en_core, 0);
    pg_sw = 1'b1; step(1);
    check("R6 core on", en_core, 1);
    check("R6 pwrok not yet", pwrok, 0);
    step(CORE - 1);
    check("R6 pwrok before settle", pwrok, 0);
    step(1);
    check("R6 pwrok after settle", pwrok, 1);
    check("R12 throttle loaded on entry", thr, 1);
    q(4'b1000, h); check("R11 on", h, 1);
  endtask

  task automatic t_throttle_on;
    thr_req = 1'b0; step(1);
    check("R12 throttle follows low", thr, 0);
    thr_req = 1'b1; step(1);
    check("R12 throttle follows high", thr, 1);
  endtask

  task automatic t_s0_to_s3;
    logic h;
    s3n = 1'b0; step(1);
    check("R8 pwrok still high", pwrok, 1);
    step(1);
    check("R8 pwrok drops first", pwrok, 0);
    check("R8 core still on", en_core, 1);
    step(1);
    check("R8 core off", en_core, 0);
    check("R8 throttle off", thr, 0);
    check("R8 sw still on", en_sw, 1);
    step(1);
    check("R8 sw off", en_sw, 0);
    q(4'b0100, h); check("R8 suspend", h, 1);
    check("R8 dsw kept", dsw, 1);
  endtask

  task automatic t_s3_to_s5;
    logic h;
    s5n = 1'b0; step(2);
    check("R9 mem off", en_mem, 0);
    q(4'b0010, h); check("R9 soft-off", h, 1);
    check("R9 dsw unchanged", dsw, 1);
  endtask

  task automatic t_on_loss;
    s5n = 1'b1; s3n = 1'b1;
    wait_for(4'b1000, 40, "R7 back to on");
    pg_sw = 1'b0; step(1);
    check("R7 dsw forced low", dsw, 0);
    check("R7 rsm forced", rsm_n, 0);
    s3n = 1'b0;
    wait_for(4'b0100, 10, "R7 suspend after loss");
    check("R7 pwrok", pwrok, 0);
    check("R7 core", en_core, 0);
    check("R7 sw", en_sw, 0);
    pg_sw = 1'b1;
  endtask

  task automatic t_priority_timeout;
    logic h;
    pg_mem = 1'b0; s3n = 1'b1; step(1);
    check("R5 rail loss beats S3 release", en_sw, 0);
    q(4'b0110, h); check("R5 heading soft-off", h, 1);
    step(1); q(4'b0010, h);
    check("R5 soft-off", h, 1);
    check("R5 mem off", en_mem, 0);
    step(1); q(4'b0110, h);
    check("R4 climb restarts", h, 1);
    step(1);
    check("R4 mem on", en_mem, 1);
    step(RAIL - 1);
    check("R4 still waiting mem", en_mem, 1);
    step(1);
    s5n = 1'b0; s3n = 1'b0;
    check("R4 timeout mem off", en_mem, 0);
    q(4'b0010, h); check("R4 timeout soft-off", h, 1);
  endtask

  task automatic t_ack;
    warn_n = 1'b0; #1;
    check("R10 ack low", ack_n, 0);
    warn_n = 1'b1; #1;
    check("R10 ack high", ack_n, 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    step(3); rst_n = 1'b1; step(1);
    t_reset;
    t_wake;
    t_idle;
    t_climb_s3;
    t_s3_to_s0;
    t_throttle_on;
    t_s0_to_s3;
    t_s3_to_s5;
    t_on_loss;
    t_priority_timeout;
    t_ack;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule